// File: doc/BRIEF.md
# TLB Invalidation Control Unit

This block holds the tag storage of two small translation lookaside buffers in an I/O memory management unit. It carries out the invalidation commands that software issues through a simple register port. Software first sets a target mask and an inclusive virtual address window. It then writes a command word. The command either wipes every entry of the selected buffers in one cycle, or starts a serial walk. The walk looks at one entry per clock and drops any valid entry whose page touches the window.

When a walk ends, a sticky completion flag is raised, and it stays up until software writes to it. Software that gives up waiting on that flag can issue a full wipe as a fallback. A fill port loads entries, and a lookup port reports hit or miss for an address. These two ports let the surrounding logic, or a bench, observe what the invalidation left behind.

Top module: `tlbi_inval_unit`

## Requirements
- R1: After synchronous reset, every entry of both buffers is invalid, all readable registers read 0, and the lookup result is 0.
- R2: Register reads return data one cycle after the address is presented. Offset 0x024 holds the window start, 0x028 holds the window end, 0x038 holds the target mask in bits [1:0] only, and any unmapped offset reads 0.
- R3: A filled entry with page-size code 0=4 KB, 1=64 KB, 2=1 MB or 3=16 MB covers the naturally aligned page that contains its tag. The lookup reports a hit one cycle after the address is presented.
- R4: Writing bit 1 to the command register at offset 0x020 makes every entry of each selected buffer invalid by the next cycle. It leaves the completion flag unchanged.
- R5: Writing bit 0 to the command register starts a walk. The walk invalidates, in the selected buffers, each valid entry whose page overlaps the window, and keeps every other entry.
- R6: The window end is inclusive. A page that begins exactly at the end address is invalidated, and a page that begins one page later is kept.
- R7: The completion flag at offset 0x12C reads 0 while a walk is running and reads 1 once the walk has examined all 16 entries. A walk ends 16 cycles after its command.
- R8: Any write to offset 0x12C clears the completion flag, unless a walk finishes in the same cycle.
- R9: A command written while a walk is running is ignored.
- R10: A buffer whose bit is 0 in the target mask is not affected by either command.
- R11: A command with both bits set performs only the full wipe, starts no walk, and does not raise the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| fill_en | input | 1 | Load one entry as valid |
| fill_tgt | input | 1 | Buffer that receives the fill |
| fill_idx | input | 4 | Entry index to fill |
| fill_vpn | input | 20 | Virtual page number (4 KB units) of the entry |
| fill_size | input | 2 | Page-size code of the entry |
| lk_tgt | input | 1 | Buffer to search |
| lk_va | input | 32 | Virtual address to search for |
| lk_hit | output | 1 | Registered hit result |

## Verification
A walk that stops early, or that runs on, shows up at the ports in two ways: entries beyond the stopping point stay visible to lookups, and the completion flag rises at the wrong time. The bench samples that flag both in the middle of a walk and after it. A wrong overlap comparison, such as an exclusive end or a mask width that does not match the page size, shows on the next lookup of a page that sits on the window boundary. A select mask applied to the wrong buffer becomes visible one cycle after the command, through a lookup in the buffer that should have been left alone.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  localparam logic [11:0] OFF_CMD   = 12'h020;
  localparam logic [11:0] OFF_START = 12'h024;
  localparam logic [11:0] OFF_END   = 12'h028;
  localparam logic [11:0] OFF_SEL   = 12'h038;
  localparam logic [11:0] OFF_DONE  = 12'h12C;

  localparam int CMD_RANGE_BIT = 0;
  localparam int CMD_ALL_BIT   = 1;

  // number of 4 KB page-number bits hidden by a larger page
  function automatic int pg_low_bits(input logic [1:0] sz);
    case (sz)
      PG_4K:   return 0;
      PG_64K:  return 4;
      PG_1M:   return 8;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/tlbi_regs.sv
module tlbi_regs
  import tlbi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int VA_W   = 32,
  parameter int N_TGT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              walk_done,
  output logic [VA_W-1:0]   start_q,
  output logic [VA_W-1:0]   end_q,
  output logic [N_TGT-1:0]  sel_q,
  output logic              done_q,
  output logic              range_go,
  output logic              full_go
);

  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFF_START);
  localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(OFF_END);
  localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(OFF_SEL);
  localparam logic [ADDR_W-1:0] A_DONE  = ADDR_W'(OFF_DONE);

  logic cmd_wr;
  assign cmd_wr   = reg_we && (reg_addr == A_CMD) && !busy;
  assign full_go  = cmd_wr && reg_wdata[CMD_ALL_BIT];
  assign range_go = cmd_wr && reg_wdata[CMD_RANGE_BIT] && !reg_wdata[CMD_ALL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_START) start_q <= reg_wdata[VA_W-1:0];
      if (reg_we && reg_addr == A_END)   end_q   <= reg_wdata[VA_W-1:0];
      if (reg_we && reg_addr == A_SEL)   sel_q   <= reg_wdata[N_TGT-1:0];
      if (walk_done)                          done_q <= 1'b1;
      else if (reg_we && reg_addr == A_DONE)  done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_START: reg_rdata <= DATA_W'(start_q);
        A_END:   reg_rdata <= DATA_W'(end_q);
        A_SEL:   reg_rdata <= DATA_W'(sel_q);
        A_DONE:  reg_rdata <= DATA_W'(done_q);
        default: reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/tlbi_walker.sv
module tlbi_walker #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int N_TGT   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             range_go,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic [VPN_W-1:0] end_vpn,
  input  logic [N_TGT-1:0] sel,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [VPN_W-1:0] s_vpn,
  output logic [VPN_W-1:0] e_vpn,
  output logic [N_TGT-1:0] act_sel,
  output logic             walk_done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  assign walk_done = busy && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      s_vpn   <= '0;
      e_vpn   <= '0;
      act_sel <= '0;
    end else if (range_go) begin
      busy    <= 1'b1;
      idx     <= '0;
      s_vpn   <= start_vpn;
      e_vpn   <= end_vpn;
      act_sel <= sel;
    end else if (busy) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/tlbi_tag_bank.sv
module tlbi_tag_bank
  import tlbi_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_all,
  input  logic               walk_en,
  input  logic [IDX_W-1:0]   walk_idx,
  input  logic [VPN_W-1:0]   s_vpn,
  input  logic [VPN_W-1:0]   e_vpn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [1:0]         fill_size,
  input  logic               lk_en,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit_q,
  output logic [ENTRIES-1:0] valid_q
);

  logic [VPN_W-1:0] tag_q  [ENTRIES];
  logic [1:0]       size_q [ENTRIES];

  function automatic logic [VPN_W-1:0] low_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] one;
    one = 1;
    return (one << pg_low_bits(sz)) - one;
  endfunction

  // storage has no reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_vpn;
      size_q[fill_idx] <= fill_size;
    end
  end

  logic [VPN_W-1:0] w_mask, w_base, w_last;
  logic             w_hit;
  always_comb begin
    w_mask = low_mask(size_q[walk_idx]);
    w_base = tag_q[walk_idx] & ~w_mask;
    w_last = tag_q[walk_idx] | w_mask;
    w_hit  = valid_q[walk_idx] && (w_base <= e_vpn) && (w_last >= s_vpn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (clear_all)             valid_q <= '0;
      else if (walk_en && w_hit) valid_q[walk_idx] <= 1'b0;
      if (fill_en)               valid_q[fill_idx] <= 1'b1;
    end
  end

  logic [ENTRIES-1:0] lk_match;
  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    logic [VPN_W-1:0] m;
    assign m = low_mask(size_q[e]);
    assign lk_match[e] = valid_q[e] && ((lk_vpn & ~m) == (tag_q[e] & ~m));
  end

  always_ff @(posedge clk) begin
    if (rst) lk_hit_q <= 1'b0;
    else     lk_hit_q <= lk_en && (|lk_match);
  end

endmodule

// File: rtl/tlbi_inval_unit.sv
module tlbi_inval_unit #(
  parameter int ENTRIES    = 16,
  parameter int N_TGT      = 2,
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int TGT_W     = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fill_en,
  input  logic [TGT_W-1:0]  fill_tgt,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [1:0]        fill_size,
  input  logic [TGT_W-1:0]  lk_tgt,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit
);

  logic [VA_W-1:0]  start_q, end_q;
  logic [N_TGT-1:0] sel_q, act_sel;
  logic             done_q, range_go, full_go;
  logic             walk_busy, walk_done;
  logic [IDX_W-1:0] walk_idx;
  logic [VPN_W-1:0] s_vpn, e_vpn;
  logic [N_TGT-1:0][ENTRIES-1:0] valid_all;
  logic [N_TGT-1:0] bank_hit;

  logic unused_lk_low;
  assign unused_lk_low = ^lk_va[PAGE_SHIFT-1:0];

  tlbi_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VA_W(VA_W), .N_TGT(N_TGT)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy(walk_busy), .walk_done(walk_done),
    .start_q(start_q), .end_q(end_q), .sel_q(sel_q), .done_q(done_q),
    .range_go(range_go), .full_go(full_go)
  );

  tlbi_walker #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .N_TGT(N_TGT)
  ) u_walk (
    .clk(clk), .rst(rst),
    .range_go(range_go),
    .start_vpn(start_q[VA_W-1:PAGE_SHIFT]),
    .end_vpn(end_q[VA_W-1:PAGE_SHIFT]),
    .sel(sel_q),
    .busy(walk_busy), .idx(walk_idx),
    .s_vpn(s_vpn), .e_vpn(e_vpn), .act_sel(act_sel),
    .walk_done(walk_done)
  );

  for (genvar t = 0; t < N_TGT; t++) begin : g_bank
    tlbi_tag_bank #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W)
    ) u_bank (
      .clk(clk), .rst(rst),
      .clear_all(full_go && sel_q[t]),
      .walk_en(walk_busy && act_sel[t]),
      .walk_idx(walk_idx),
      .s_vpn(s_vpn), .e_vpn(e_vpn),
      .fill_en(fill_en && (fill_tgt == TGT_W'(t))),
      .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_size(fill_size),
      .lk_en(lk_tgt == TGT_W'(t)),
      .lk_vpn(lk_va[VA_W-1:PAGE_SHIFT]),
      .lk_hit_q(bank_hit[t]),
      .valid_q(valid_all[t])
    );
  end

  assign lk_hit = |bank_hit;

endmodule

// File: rtl/tlbi_checker.sv
module tlbi_checker #(
  parameter int ENTRIES = 16,
  parameter int N_TGT   = 2,
  parameter int ADDR_W  = 12
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          reg_we,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic                          busy,
  input logic                          walk_done,
  input logic                          done_q,
  input logic                          full_go,
  input logic [N_TGT-1:0]              sel_q,
  input logic                          fill_en,
  input logic [N_TGT-1:0][ENTRIES-1:0] valid_all
);

  localparam int CNT_W = $clog2(ENTRIES + 2) + 1;
  localparam logic [ADDR_W-1:0] A_DONE = ADDR_W'(tlbi_pkg::OFF_DONE);

  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_q);                                         // R7

  AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= CNT_W'(ENTRIES));                                    // R7

  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_DONE && !walk_done) |=> !done_q);       // R8

  AST_FULL_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (full_go && !done_q) |=> !done_q);                               // R11

  AST_FULL_IDLE: assert property (@(posedge clk) disable iff (rst)
    full_go |-> !busy);                                              // R9

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (full_go && sel_q[t] && !fill_en) |=> (valid_all[t] == '0));   // R4
  end

endmodule

bind tlbi_inval_unit tlbi_checker #(
  .ENTRIES(ENTRIES), .N_TGT(N_TGT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst),
  .reg_we(reg_we), .reg_addr(reg_addr),
  .busy(walk_busy), .walk_done(walk_done), .done_q(done_q),
  .full_go(full_go), .sel_q(sel_q), .fill_en(fill_en),
  .valid_all(valid_all)
);

// File: tb/tlbi_inval_unit_tb.sv
module tlbi_inval_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fill_en = 1'b0;
  logic        fill_tgt = 1'b0;
  logic [3:0]  fill_idx = '0;
  logic [19:0] fill_vpn = '0;
  logic [1:0]  fill_size = '0;
  logic        lk_tgt = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  tlbi_inval_unit u_dut (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .fill_en(fill_en), .fill_tgt(fill_tgt), .fill_idx(fill_idx),
    .fill_vpn(fill_vpn), .fill_size(fill_size),
    .lk_tgt(lk_tgt), .lk_va(lk_va), .lk_hit(lk_hit)
  );

  // {vpn, size code, lookup address, expected hit}
  localparam logic [54:0] LK_VEC [8] = '{
    {20'h00010, 2'd0, 32'h0001_0ABC, 1'b1},
    {20'h00010, 2'd0, 32'h0001_1000, 1'b0},
    {20'h00020, 2'd1, 32'h0002_FFFC, 1'b1},
    {20'h00023, 2'd1, 32'h0002_0004, 1'b1},
    {20'h00020, 2'd1, 32'h0003_0000, 1'b0},
    {20'h00100, 2'd2, 32'h001F_F000, 1'b1},
    {20'h01000, 2'd3, 32'h01FF_FFFF, 1'b1},
    {20'h01000, 2'd3, 32'h00FF_FFFF, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic fill(input logic t, input logic [3:0] i, input logic [19:0] v, input logic [1:0] s);
    @(negedge clk);
    fill_en = 1'b1; fill_tgt = t; fill_idx = i; fill_vpn = v; fill_size = s;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic look(input logic t, input logic [31:0] va, output logic h);
    @(negedge clk);
    lk_tgt = t; lk_va = va;
    @(negedge clk);
    h = lk_hit;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic h;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(12'h024, d); chk("R1 start", d, 0);
    rd(12'h038, d); chk("R1 sel", d, 0);
    rd(12'h12C, d); chk("R1 done", d, 0);
    look(1'b0, 32'h0, h); chk("R1 lookup", {31'd0, h}, 0);

    // R2 register readback
    wr(12'h024, 32'h1234_5678); rd(12'h024, d); chk("R2 start", d, 32'h1234_5678);
    wr(12'h028, 32'h0BAD_F00D); rd(12'h028, d); chk("R2 end", d, 32'h0BAD_F00D);
    wr(12'h038, 32'hFFFF_FFFF); rd(12'h038, d); chk("R2 sel", d, 32'h3);
    rd(12'h100, d); chk("R2 unmapped", d, 0);

    // R3 page-size lookups from the vector table
    foreach (LK_VEC[k]) begin
      fill(1'b0, 4'd0, LK_VEC[k][54:35], LK_VEC[k][34:33]);
      look(1'b0, LK_VEC[k][32:1], h);
      chk($sformatf("R3 vec%0d", k), {31'd0, h}, {31'd0, LK_VEC[k][0]});
    end

    // R4 full wipe on both targets, done untouched
    fill(1'b1, 4'd3, 20'h00040, 2'd0);
    wr(12'h020, 32'h2);
    look(1'b0, 32'h0100_0000, h); chk("R4 t0 wiped", {31'd0, h}, 0);
    look(1'b1, 32'h0004_0000, h); chk("R4 t1 wiped", {31'd0, h}, 0);
    rd(12'h12C, d); chk("R4 done unchanged", d, 0);

    // R10 full wipe restricted to target 1
    fill(1'b0, 4'd0, 20'h00040, 2'd0);
    fill(1'b1, 4'd0, 20'h00040, 2'd0);
    wr(12'h038, 32'h2);
    wr(12'h020, 32'h2);
    look(1'b0, 32'h0004_0000, h); chk("R10 t0 kept", {31'd0, h}, 1);
    look(1'b1, 32'h0004_0000, h); chk("R10 t1 wiped", {31'd0, h}, 0);

    // range setup: clear all, load both targets alike
    wr(12'h038, 32'h3);
    wr(12'h020, 32'h2);
    for (int t = 0; t < 2; t++) begin
      fill(t[0], 4'd0, 20'h00010, 2'd0);
      fill(t[0], 4'd1, 20'h00020, 2'd1);
      fill(t[0], 4'd2, 20'h00100, 2'd2);
      fill(t[0], 4'd3, 20'h01000, 2'd3);
      fill(t[0], 4'd4, 20'h00030, 2'd0);
      fill(t[0], 4'd5, 20'h00031, 2'd0);
    end
    wr(12'h038, 32'h1);
    wr(12'h024, 32'h0002_8000);
    wr(12'h028, 32'h0003_0000);
    wr(12'h020, 32'h1);
    wr(12'h020, 32'h2);   // R9 issued during the walk
    rd(12'h12C, d); chk("R7 done low mid-walk", d, 0);
    repeat (20) @(negedge clk);
    rd(12'h12C, d); chk("R7 done after walk", d, 1);
    look(1'b0, 32'h0001_0000, h); chk("R9 busy command ignored", {31'd0, h}, 1);
    look(1'b0, 32'h0002_0000, h); chk("R5 overlapped 64K removed", {31'd0, h}, 0);
    look(1'b0, 32'h0010_0000, h); chk("R5 1M kept", {31'd0, h}, 1);
    look(1'b0, 32'h0100_0000, h); chk("R5 16M kept", {31'd0, h}, 1);
    look(1'b0, 32'h0003_0000, h); chk("R6 page at end removed", {31'd0, h}, 0);
    look(1'b0, 32'h0003_1000, h); chk("R6 page past end kept", {31'd0, h}, 1);
    look(1'b1, 32'h0002_0000, h); chk("R10 unselected target kept", {31'd0, h}, 1);

    // R8 clear done
    wr(12'h12C, 32'h0);
    rd(12'h12C, d); chk("R8 done cleared", d, 0);

    // R11 both bits: full wipe only
    wr(12'h038, 32'h3);
    wr(12'h020, 32'h3);
    repeat (20) @(negedge clk);
    rd(12'h12C, d); chk("R11 done stays low", d, 0);
    look(1'b0, 32'h0003_1000, h); chk("R11 t0 wiped", {31'd0, h}, 0);
    look(1'b1, 32'h0002_0000, h); chk("R11 t1 wiped", {31'd0, h}, 0);

    finish_run();
  end

endmodule